// File: doc/BRIEF.md
# Interrupt Priority Register File with Secure/Non-Secure Views

This block holds one 8-bit priority byte for every interrupt of a distributor and exposes it to software through byte and word accesses. A word covers four consecutive interrupts. Every access carries a secure attribute. Together with a per-interrupt group bit and a global security-disable input, that attribute decides whether a non-secure agent may touch an entry and which view of the value it gets. The whole table is driven out flat on `prio_out`, so an external arbiter can compare priorities. Arbitration is not part of this block.

A non-secure agent that is allowed to touch an entry works on a rescaled copy of the value. It reads the stored value shifted up by one bit. Every value it writes lands in the upper half of the range, which is the numerically larger, lower-urgency half. Entries whose group bit is clear are invisible to such an agent. Entries for the private interrupts below 32, and for indices past the implemented count, are absent for every agent.

Requests are processed by a two-state controller. In `ST_IDLE`, `req_ready` is high. A request with `req_valid` high is taken ("accept" transition) and the controller moves to `ST_EXEC`. In `ST_EXEC`, the write commits or the read data is formed, and the controller returns to `ST_IDLE` ("complete" transition) while raising `rsp_valid` for one cycle.

Top module: `irq_prio_bank`

## Requirements
- R1: For a non-secure access while `sec_disable` is 0, an entry whose `grp_bits` bit is 0 reads as 0x00 and is not changed by writes.
- R2: A non-secure read of a permitted entry (security enabled, group bit 1) returns the stored byte shifted left by one, truncated to 8 bits (bit 0 is 0).
- R3: A non-secure write to a permitted entry stores 0x80 OR (written byte >> 1).
- R4: A secure access, or any access while `sec_disable` is 1, reads and writes the raw stored byte, whatever the group bit.
- R5: Indices below 32 or at or above NUM_IRQ read as 0x00 and are never written.
- R6: A word read returns interrupt base+k in bits [8k+7:8k] for k = 0..3. A byte read returns the entry in bits [7:0] with bits [31:8] zero.
- R7: A word write whose last index (base+3) is at or above NUM_IRQ changes no entry at all, including the in-range lanes.
- R8: The byte address is the interrupt index (`req_word` = 0 selects byte, 1 selects word). For word accesses, address bits [1:0] are ignored and base = address with those bits cleared. For word writes, byte k of `req_wdata` goes to base+k.
- R9: After reset every priority is 0x00. `prio_out[8i+7:8i]` always carries the stored priority of interrupt i.
- R10: `req_ready` is high in `ST_IDLE`. A request accepted at a clock edge raises `rsp_valid` for exactly one cycle after the following edge. That same edge commits any write. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = four-byte access, 0 = single byte |
| req_secure | input | 1 | Secure attribute of the access |
| req_addr | input | ADDR_W | Byte address equal to the interrupt index |
| req_wdata | input | 32 | Write data; byte access uses bits [7:0] |
| grp_bits | input | NUM_IRQ | Group bit per interrupt (1 = non-secure group) |
| sec_disable | input | 1 | 1 = single security state; all accesses see raw values |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| prio_out | output | NUM_IRQ*8 | Stored priority of every interrupt, flat |

## Verification
The assertions assume that `grp_bits` and `sec_disable` stay steady from the accept edge to the complete edge. They also assume that `req_valid` is raised only when the bench intends a new request. The permission and view checks sample these inputs in `ST_EXEC` and relate them to the response one edge later. The stimulus changes the group bits and the security-disable input only on the falling edge before a request is driven, never while one is in flight. The bench also holds exactly one request outstanding at a time. Random addresses cover the whole address space, including the private range, the partial last word and indices past NUM_IRQ, so the range and drop rules are exercised together with the secure/non-secure views.

// File: rtl/prio_pkg.sv
package prio_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } prio_state_e;

    localparam int LANES = 4;

    // Value seen by a restricted agent when it reads a stored byte.
    function automatic logic [7:0] ns_read_view(input logic [7:0] raw);
        return {raw[6:0], 1'b0};
    endfunction

    // Value stored when a restricted agent writes a byte.
    function automatic logic [7:0] ns_write_view(input logic [7:0] wr);
        return {1'b1, wr[7:1]};
    endfunction

endpackage

// File: rtl/prio_ctrl_fsm.sv
module prio_ctrl_fsm
    import prio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    output logic accept,
    output logic exec,
    output logic rsp_valid
);

    prio_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready = 1'b0;
        exec      = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_EXEC: exec      = 1'b1;
            default: req_ready = 1'b0;
        endcase
        accept = req_ready && req_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= exec;
    end

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10
    AST_ACCEPT_TO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!req_ready ##1 rsp_valid)); // R10

endmodule

// File: rtl/prio_lane_gate.sv
module prio_lane_gate
    import prio_pkg::*;
#(
    parameter int NUM_IRQ      = 70,
    parameter int FIRST_SHARED = 32,
    parameter int IW           = 11
) (
    input  logic [IW-1:0] idx,
    input  logic          active,
    input  logic          ns_restr,
    input  logic          grp_bit,
    input  logic [7:0]    stored,
    input  logic [7:0]    wbyte,
    output logic          permit,
    output logic [7:0]    rbyte,
    output logic [7:0]    wview
);

    logic in_range;

    always_comb begin
        in_range = (int'(idx) >= FIRST_SHARED) && (int'(idx) < NUM_IRQ);
        permit   = active && in_range && (!ns_restr || grp_bit);
        if (!permit)       rbyte = 8'h00;
        else if (ns_restr) rbyte = ns_read_view(stored);
        else               rbyte = stored;
        wview = ns_restr ? ns_write_view(wbyte) : wbyte;
    end

endmodule

// File: rtl/prio_store.sv
module prio_store
    import prio_pkg::*;
#(
    parameter int NUM_IRQ      = 70,
    parameter int FIRST_SHARED = 32,
    parameter int EW           = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LANES-1:0]     we,
    input  logic [EW-1:0]        widx [LANES],
    input  logic [7:0]           wdat [LANES],
    output logic [NUM_IRQ*8-1:0] prio_flat
);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_entry
        logic [7:0] val_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= 8'h00;
            end else begin
                for (int k = 0; k < LANES; k++) begin
                    if (we[k] && (int'(widx[k]) == i)) val_q <= wdat[k];
                end
            end
        end
        assign prio_flat[i*8 +: 8] = val_q;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        AST_STORE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
            we[k] |-> (int'(widx[k]) >= FIRST_SHARED)); // R5
    end

endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
    import prio_pkg::*;
#(
    parameter int NUM_IRQ      = 70,
    parameter int ADDR_W       = 10,
    parameter int FIRST_SHARED = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic                 req_word,
    input  logic                 req_secure,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [31:0]          req_wdata,
    input  logic [NUM_IRQ-1:0]   grp_bits,
    input  logic                 sec_disable,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    output logic [NUM_IRQ*8-1:0] prio_out
);

    localparam int IW = ADDR_W + 1;
    localparam int EW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic accept, exec;

    prio_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .accept    (accept),
        .exec      (exec),
        .rsp_valid (rsp_valid)
    );

    // Request capture
    logic              rq_write, rq_word, rq_secure;
    logic [ADDR_W-1:0] rq_addr;
    logic [31:0]       rq_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_write  <= 1'b0;
            rq_word   <= 1'b0;
            rq_secure <= 1'b0;
            rq_addr   <= '0;
            rq_wdata  <= '0;
        end else if (accept) begin
            rq_write  <= req_write;
            rq_word   <= req_word;
            rq_secure <= req_secure;
            rq_addr   <= req_addr;
            rq_wdata  <= req_wdata;
        end
    end

    logic [IW-1:0] base_ext;
    logic          ns_restr;
    logic          word_drop;

    always_comb begin
        base_ext  = rq_word ? {1'b0, rq_addr[ADDR_W-1:2], 2'b00} : {1'b0, rq_addr};
        ns_restr  = !rq_secure && !sec_disable;
        word_drop = rq_word && ((int'(base_ext) + LANES - 1) >= NUM_IRQ);
    end

    // Unpacked view of the table
    logic [7:0] prio_arr [NUM_IRQ];
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_unpack
        assign prio_arr[i] = prio_out[i*8 +: 8];
    end

    logic [IW-1:0]    idx    [LANES];
    logic [EW-1:0]    sel    [LANES];
    logic [7:0]       wview  [LANES];
    logic [7:0]       rbyte  [LANES];
    logic [LANES-1:0] permit;
    logic [LANES-1:0] we;
    logic [31:0]      rd_comb;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic active, in_tab, grp_sel;
        logic [7:0] stored;

        assign active  = rq_word || (k == 0);
        assign idx[k]  = base_ext + IW'(k);
        assign in_tab  = int'(idx[k]) < NUM_IRQ;
        assign sel[k]  = in_tab ? idx[k][EW-1:0] : '0;
        assign grp_sel = grp_bits[sel[k]];
        assign stored  = prio_arr[sel[k]];

        prio_lane_gate #(
            .NUM_IRQ      (NUM_IRQ),
            .FIRST_SHARED (FIRST_SHARED),
            .IW           (IW)
        ) u_gate (
            .idx      (idx[k]),
            .active   (active),
            .ns_restr (ns_restr),
            .grp_bit  (grp_sel),
            .stored   (stored),
            .wbyte    (rq_wdata[k*8 +: 8]),
            .permit   (permit[k]),
            .rbyte    (rbyte[k]),
            .wview    (wview[k])
        );

        assign we[k] = exec && rq_write && permit[k] && !word_drop;
        assign rd_comb[k*8 +: 8] = rbyte[k];
    end

    prio_store #(
        .NUM_IRQ      (NUM_IRQ),
        .FIRST_SHARED (FIRST_SHARED),
        .EW           (EW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we),
        .widx      (sel),
        .wdat      (wview),
        .prio_flat (prio_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)    rsp_rdata <= '0;
        else if (exec) rsp_rdata <= rq_write ? 32'h0 : rd_comb;
    end

    // Byte read of a hidden entry returns zero
    AST_HIDDEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !rq_write && !rq_word && ns_restr && (int'(base_ext) < NUM_IRQ)
         && !grp_bits[sel[0]]) |=> (rsp_rdata == 32'h0)); // R1
    // Restricted byte writes land in the upper half
    AST_NS_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !rq_word && ns_restr && we[0]) |=> prio_arr[sel[0]][7]); // R3
    // Overhanging word writes leave the table untouched
    AST_WORD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && rq_write && rq_word && ((int'(base_ext) + LANES - 1) >= NUM_IRQ))
        |=> $stable(prio_out)); // R7
    // Byte reads outside the shared range return zero
    AST_RANGE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !rq_write && !rq_word &&
         ((int'(base_ext) < FIRST_SHARED) || (int'(base_ext) >= NUM_IRQ)))
        |=> (rsp_rdata == 32'h0)); // R5

endmodule

// File: tb/irq_prio_bank_test.sv
module irq_prio_bank_test;

    localparam int NUM_IRQ = 70;
    localparam int ADDR_W  = 10;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic                 req_write = 1'b0;
    logic                 req_word = 1'b0;
    logic                 req_secure = 1'b0;
    logic [ADDR_W-1:0]    req_addr = '0;
    logic [31:0]          req_wdata = '0;
    logic [NUM_IRQ-1:0]   grp_bits = '0;
    logic                 sec_disable = 1'b0;
    logic                 rsp_valid;
    logic [31:0]          rsp_rdata;
    logic [NUM_IRQ*8-1:0] prio_out;

    irq_prio_bank #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .FIRST_SHARED(32)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_word(req_word), .req_secure(req_secure),
        .req_addr(req_addr), .req_wdata(req_wdata), .grp_bits(grp_bits),
        .sec_disable(sec_disable), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .prio_out(prio_out)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    logic [7:0] mdl [NUM_IRQ];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit permitted(input int idx, input bit sec);
        if (idx < 32 || idx >= NUM_IRQ) return 1'b0;
        return sec || sec_disable || grp_bits[idx];
    endfunction

    function automatic logic [31:0] exp_read(input bit word, input bit sec, input int addr);
        int base;
        int lanes;
        logic [31:0] r;
        bit ns;
        base  = word ? (addr & ~3) : addr;
        lanes = word ? 4 : 1;
        ns    = !sec && !sec_disable;
        r     = '0;
        for (int k = 0; k < lanes; k++) begin
            int ix;
            ix = base + k;
            if (permitted(ix, sec))
                r[k*8 +: 8] = ns ? {mdl[ix][6:0], 1'b0} : mdl[ix];
        end
        return r;
    endfunction

    task automatic model_write(input bit word, input bit sec, input int addr, input logic [31:0] d);
        int base;
        int lanes;
        bit ns;
        base  = word ? (addr & ~3) : addr;
        lanes = word ? 4 : 1;
        ns    = !sec && !sec_disable;
        if (word && (base + 3 >= NUM_IRQ)) return;
        for (int k = 0; k < lanes; k++) begin
            int ix;
            logic [7:0] b;
            ix = base + k;
            b  = d[k*8 +: 8];
            if (permitted(ix, sec)) mdl[ix] = ns ? {1'b1, b[7:1]} : b;
        end
    endtask

    task automatic check_table(input string tag);
        logic [NUM_IRQ*8-1:0] flat;
        for (int i = 0; i < NUM_IRQ; i++) flat[i*8 +: 8] = mdl[i];
        n_checks++;
        if (prio_out !== flat) begin
            n_fail++;
            $display("FAIL %s table: actual=%h expected=%h", tag, prio_out, flat);
        end
    endtask

    task automatic access(input bit w, input bit word, input bit sec, input int addr,
                          input logic [31:0] d, input string tag, output logic [31:0] rd);
        logic [31:0] exp;
        @(negedge clk);
        check({tag, " R10 ready"}, {31'b0, req_ready}, 32'd1);
        exp        = w ? 32'h0 : exp_read(word, sec, addr);
        req_valid  = 1'b1;
        req_write  = w;
        req_word   = word;
        req_secure = sec;
        req_addr   = ADDR_W'(addr);
        req_wdata  = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check({tag, " R10 rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
        check({tag, " data"}, rsp_rdata, exp);
        rd = rsp_rdata;
        if (w) model_write(word, sec, addr, d);
        check_table({tag, " R9"});
    endtask

    initial begin
        logic [31:0] rd;
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < NUM_IRQ; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_table("R9 reset");
        check("R10 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);

        // Raw secure path
        access(1, 0, 1, 40, 32'h5A, "R4 sec write", rd);
        access(0, 0, 1, 40, 0, "R4 sec read", rd);
        check("R4 raw value", rd, 32'h5A);
        @(negedge clk);
        check("R10 single pulse", {31'b0, rsp_valid}, 32'd0);

        // Restricted views
        grp_bits[40] = 1'b1;
        access(0, 0, 0, 40, 0, "R2 ns read", rd);
        check("R2 shifted", rd, 32'hB4);
        grp_bits[40] = 1'b0;
        access(0, 0, 0, 40, 0, "R1 ns hidden read", rd);
        check("R1 hidden zero", rd, 32'h0);
        access(1, 0, 0, 40, 32'h11, "R1 ns hidden write", rd);
        check("R1 unchanged", {24'b0, prio_out[40*8 +: 8]}, 32'h5A);
        grp_bits[41] = 1'b1;
        access(1, 0, 0, 41, 32'h33, "R3 ns write", rd);
        check("R3 stored", {24'b0, prio_out[41*8 +: 8]}, 32'h99);
        access(0, 0, 0, 41, 0, "R2 ns readback", rd);
        check("R2 readback", rd, 32'h32);

        // Single security state
        sec_disable = 1'b1;
        access(1, 0, 0, 42, 32'h07, "R4 sd write", rd);
        check("R4 sd raw", {24'b0, prio_out[42*8 +: 8]}, 32'h07);
        sec_disable = 1'b0;

        // Range edges
        access(1, 0, 1, 10, 32'hFF, "R5 private write", rd);
        access(0, 0, 1, 10, 0, "R5 private read", rd);
        check("R5 private zero", rd, 32'h0);
        access(0, 0, 1, 80, 0, "R5 beyond read", rd);
        check("R5 beyond zero", rd, 32'h0);

        // Word accesses
        access(1, 1, 1, 45, 32'h44332211, "R8 word write", rd);
        check("R8 lane0", {24'b0, prio_out[44*8 +: 8]}, 32'h11);
        access(0, 1, 1, 46, 0, "R6 word read", rd);
        check("R6 order", rd, 32'h44332211);
        access(0, 0, 1, 45, 0, "R6 byte read", rd);
        check("R6 byte", rd, 32'h22);
        access(1, 0, 1, 68, 32'hAB, "R7 prep", rd);
        access(1, 1, 1, 68, 32'hDDCCBBAA, "R7 overhang write", rd);
        check("R7 dropped", {24'b0, prio_out[68*8 +: 8]}, 32'hAB);
        access(0, 1, 1, 68, 0, "R6 partial word read", rd);
        check("R6 partial", rd, 32'h000000AB);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            bit w, wd, sc;
            int a;
            @(negedge clk);
            grp_bits    = {$urandom, $urandom, $urandom};
            sec_disable = ($urandom % 8) == 0;
            w  = $urandom % 2;
            wd = $urandom % 2;
            sc = $urandom % 2;
            a  = ($urandom % 4 == 0) ? int'($urandom % 1024) : int'($urandom % 80);
            access(w, wd, sc, a, $urandom, w ? "R3 R4 R7 rnd write" : "R1 R2 R6 rnd read", rd);
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule